// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is an SPI slave that lets an external master read and write a 64-entry, 8-bit register file. SCLK, the active-low select and MOSI come in asynchronously. Each one passes through a two-flop synchronizer clocked by a faster system clock. The block finds the SCLK edges in that clock domain and drives MISO back out. The bus runs with clock idle low and data captured on the trailing edge. The slave shifts MISO on each detected SCLK rise and captures MOSI on each detected SCLK fall. Bits travel most significant first.

Every transaction opens with a header byte. The header gives a 6-bit register address, a direction bit and a stream bit. From these the controller runs one of four cases:

- a single read;
- a single write;
- a burst read, whose second byte gives the number of data bytes;
- a burst write, which keeps taking bytes until the select line is released.

Within a burst the register address steps up by one after each data byte and wraps around at the top of the register file.

A separate host port lets surrounding logic preload and inspect the registers in parallel with the serial side.

Top module: `spi_regslave`

## Requirements
- R1: Each exchange is 8 SCLK cycles with the bus select held low. MOSI is captured on the SCLK falling edge and MISO changes on the SCLK rising edge, most significant bit first.
- R2: The first byte after select falls is the header: bits 7..2 are the register address, bit 1 is direction (1 = write, 0 = read), and bit 0 selects burst (1) or single (0). MISO is 0 for the whole header exchange.
- R3: A single read (header bits 1..0 = 00) returns the addressed register on MISO in exchange 2. MOSI in that exchange changes no register.
- R4: A single write (header bits 1..0 = 10) stores the exchange-2 MOSI byte in the addressed register. MISO stays 0 for the whole transaction.
- R5: A burst read (header bits 1..0 = 01) takes a count N from MOSI in exchange 2. It then returns N register bytes on MISO in exchanges 3 to N+2. MISO is 0 during the count exchange.
- R6: A burst write (header bits 1..0 = 11) stores every byte after the header, until select rises. MISO stays 0 throughout.
- R7: In a burst, the register address advances by one after each data byte and wraps from 63 to 0.
- R8: After a burst read has sent its N bytes (including N = 0), MISO is 0 and further exchanges have no effect until select rises.
- R9: Select rising at any time returns the controller to the header stage and discards a partial byte. An incomplete write byte is never stored.
- R10: The host port writes the register at host_addr when host_we is high. host_rdata shows the register at host_addr combinationally. A serial write wins over a host write to the same register in the same cycle.
- R11: After reset, MISO is 0 and all registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The bench targets several corner cases:

- Address wrap from 63 to 0 in both burst directions. A controller without the wrap would read or write beyond the file, or lose the second byte.
- A burst read whose count is zero, and a burst read with one extra exchange after the count is used up. A design that failed to stop would leak the next register onto MISO.
- Select pulled high partway through a write byte, and partway through a header. A design that kept the partial byte would commit garbage or misframe the next transaction.
- A single read with all-ones on MOSI. This shows whether ignored data ever reaches the register file.

// File: rtl/spi_regslave_pkg.sv
`timescale 1ns/1ps
package spi_regslave_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_HDR   = 3'd0,
    ST_LEN   = 3'd1,
    ST_SRD   = 3'd2,
    ST_SWR   = 3'd3,
    ST_BRD   = 3'd4,
    ST_BWR   = 3'd5,
    ST_DRAIN = 3'd6
  } seq_state_e;

  // header layout: address in the upper six bits, then direction, then burst
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              burst;
  } hdr_t;

  function automatic hdr_t decode_hdr(input logic [BYTE_W-1:0] b);
    return hdr_t'(b);
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic seq_state_e first_state(input hdr_t h);
    if (h.burst) return h.wr ? ST_BWR : ST_LEN;
    return h.wr ? ST_SWR : ST_SRD;
  endfunction

endpackage

// File: rtl/spi_rs_bitsync.sv
`timescale 1ns/1ps
module spi_rs_bitsync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rs_frontend.sv
`timescale 1ns/1ps
module spi_rs_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ss_idle,
  output logic mosi_s
);
  logic sclk_s;
  logic sclk_d;

  spi_rs_bitsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  spi_rs_bitsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_idle));
  spi_rs_bitsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
endmodule

// File: rtl/spi_rs_shifter.sv
`timescale 1ns/1ps
module spi_rs_shifter
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              ss_idle,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              load_strobe,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  // a new byte is loaded on the first rising edge of each exchange
  assign load_strobe = sclk_rise && !ss_idle && (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (ss_idle) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
      end else begin
        if (sclk_fall) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
        end
        if (sclk_rise) begin
          if (bit_cnt == '0) tx_sh <= tx_byte;
          else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_byte = rx_sh;
  assign miso    = tx_sh[BYTE_W-1];

  // R9: a released select leaves no partial bit count and a quiet MISO
  p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_idle |=> (bit_cnt == '0) && !miso);

  // R1: a completed byte is reported only right after a falling edge
  p_byte_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sclk_fall));
endmodule

// File: rtl/spi_rs_seq.sv
`timescale 1ns/1ps
module spi_rs_seq
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ss_idle,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BYTE_W-1:0] wr_data,
  output seq_state_e        state
);
  logic [BYTE_W-1:0] remain;
  hdr_t              hdr;
  logic              addr_adv;

  assign hdr      = decode_hdr(rx_byte);
  assign tx_byte  = (state == ST_SRD || state == ST_BRD) ? rd_data : '0;
  assign wr_en    = byte_done && !ss_idle && (state == ST_SWR || state == ST_BWR);
  assign wr_data  = rx_byte;
  assign addr_adv = byte_done && !ss_idle && (state == ST_BRD || state == ST_BWR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_HDR;
      cur_addr <= '0;
      remain   <= '0;
    end else if (ss_idle) begin
      state <= ST_HDR;
    end else if (byte_done) begin
      case (state)
        ST_HDR: begin
          cur_addr <= hdr.addr;
          state    <= first_state(hdr);
        end
        ST_LEN: begin
          remain <= rx_byte;
          state  <= (rx_byte == '0) ? ST_DRAIN : ST_BRD;
        end
        ST_SRD, ST_SWR: state <= ST_DRAIN;
        ST_BRD: begin
          cur_addr <= next_addr(cur_addr);
          remain   <= remain - 1'b1;
          if (remain == BYTE_W'(1)) state <= ST_DRAIN;
        end
        ST_BWR:   cur_addr <= next_addr(cur_addr);
        ST_DRAIN: state <= ST_DRAIN;
        default:  state <= ST_HDR;
      endcase
    end
  end

  // R7: stepping past the top address lands on register 0
  p_addr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_adv && cur_addr == ADDR_W'(DEPTH - 1)) |=> (cur_addr == '0));

  // R5: a burst read never runs with nothing left to send
  p_burst_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRD) |-> (remain != '0));

  // R8: after draining, only a released select leaves the drain stage
  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !ss_idle) |=> (state == ST_DRAIN || $past(ss_idle) || ss_idle || state == ST_HDR));
endmodule

// File: rtl/spi_rs_regfile.sv
`timescale 1ns/1ps
module spi_rs_regfile
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_we,
  input  logic [ADDR_W-1:0] spi_addr,
  input  logic [BYTE_W-1:0] spi_wdata,
  output logic [BYTE_W-1:0] spi_rdata,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // serial write is applied last so it wins a same-register collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_addr] <= host_wdata;
      if (spi_we)  mem[spi_addr]  <= spi_wdata;
    end
  end

  assign spi_rdata  = mem[spi_addr];
  assign host_rdata = mem[host_addr];

  // verification tracking of the most recent serial write
  logic              chk_we;
  logic [ADDR_W-1:0] chk_addr;
  logic [BYTE_W-1:0] chk_data;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_we   <= 1'b0;
      chk_addr <= '0;
      chk_data <= '0;
    end else begin
      chk_we   <= spi_we;
      chk_addr <= spi_addr;
      chk_data <= spi_wdata;
    end
  end

  // R10: a serial write is visible next cycle even against a host write
  p_spi_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_we |-> (mem[chk_addr] == chk_data));
endmodule

// File: rtl/spi_regslave.sv
`timescale 1ns/1ps
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  logic              sclk_rise, sclk_fall, ss_idle, mosi_s;
  logic              byte_done, load_strobe;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] cur_addr;
  seq_state_e        state;

  spi_rs_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_idle(ss_idle), .mosi_s(mosi_s));

  spi_rs_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ss_idle(ss_idle), .mosi_s(mosi_s), .tx_byte(tx_byte), .miso(miso),
    .byte_done(byte_done), .rx_byte(rx_byte), .load_strobe(load_strobe),
    .bit_cnt(bit_cnt));

  spi_rs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .ss_idle(ss_idle), .rd_data(rd_data), .tx_byte(tx_byte), .wr_en(wr_en),
    .cur_addr(cur_addr), .wr_data(wr_data), .state(state));

  spi_rs_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .spi_we(wr_en), .spi_addr(cur_addr),
    .spi_wdata(wr_data), .spi_rdata(rd_data), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  // R2: the header exchange is silent on MISO
  p_hdr_miso_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> !miso);

  // R8: a byte loaded while draining puts nothing on MISO
  p_drain_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && state == ST_DRAIN) |=> !miso);

  // R4: a register is committed only with select low and a full byte count
  p_commit_full_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (bit_cnt == '0) && !ss_idle);

  // R6: during a burst write MISO carries nothing
  p_bwr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BWR && $past(state) == ST_BWR) |-> !miso);
endmodule

// File: tb/spi_regslave_bench.sv
`timescale 1ns/1ps
module spi_regslave_bench;
  localparam int HALF = 8;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic       host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  spi_regslave u_spi_regslave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  // {header, exchange-2 MOSI, preload, expected exchange-2 MISO, expected register}
  localparam logic [39:0] VECS [0:5] = '{
    40'h58_FF_A5_A5_A5,   // R3 read 0x16, MOSI all ones ignored
    40'hF6_B4_00_00_B4,   // R4 write 0x3D
    40'h00_55_3C_3C_3C,   // R3 read 0x00
    40'hFE_81_7E_00_81,   // R4 write 0x3F
    40'hFC_00_C3_C3_C3,   // R3 read 0x3F
    40'h06_FF_00_00_FF    // R4 write 0x01
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = tx[7-i];
      wait_clks(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b0;
      wait_clks(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic sel;
    ss_n = 1'b0;
    wait_clks(HALF);
  endtask

  task automatic desel;
    wait_clks(HALF);
    ss_n = 1'b1;
    mosi = 1'b0;
    wait_clks(2 * HALF);
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    wait_clks(1);
    host_we = 1'b0;
  endtask

  task automatic hcheck(input string req, input logic [5:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    check(req, host_rdata, exp);
  endtask

  initial begin
    #(WD_CYCLES * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);

    // R11 reset state
    check("R11 miso", {7'b0, miso}, 8'h00);
    hcheck("R11 reg5", 6'd5, 8'h00);
    hcheck("R11 reg63", 6'd63, 8'h00);

    // single transactions from the vector table (R1, R2, R3, R4)
    for (int v = 0; v < 6; v++) begin
      logic [7:0] hb, db, pre, erx, ereg;
      {hb, db, pre, erx, ereg} = VECS[v];
      hwrite(hb[7:2], pre);
      sel();
      xfer(hb, rx);
      check("R2 header miso", rx, 8'h00);
      xfer(db, rx);
      check(hb[1] ? "R4 write miso" : "R3 read data R1", rx, erx);
      desel();
      hcheck(hb[1] ? "R4 stored" : "R3 mosi ignored", hb[7:2], ereg);
    end

    // R5 burst read of three, then one surplus exchange (R8)
    hwrite(6'h16, 8'hA5); hwrite(6'h17, 8'hBF); hwrite(6'h18, 8'h4D); hwrite(6'h19, 8'hEE);
    sel();
    xfer(8'h59, rx); check("R2 burst header", rx, 8'h00);
    xfer(8'h03, rx); check("R5 count exchange", rx, 8'h00);
    xfer(8'h00, rx); check("R5 byte0", rx, 8'hA5);
    xfer(8'h00, rx); check("R5 byte1", rx, 8'hBF);
    xfer(8'h00, rx); check("R5 byte2", rx, 8'h4D);
    xfer(8'h00, rx); check("R8 surplus zero", rx, 8'h00);
    desel();

    // R7 burst read across the top address
    hwrite(6'd62, 8'h62); hwrite(6'd63, 8'h63); hwrite(6'd0, 8'h70);
    sel();
    xfer(8'hF9, rx);
    xfer(8'h03, rx);
    xfer(8'h00, rx); check("R7 rd 62", rx, 8'h62);
    xfer(8'h00, rx); check("R7 rd 63", rx, 8'h63);
    xfer(8'h00, rx); check("R7 rd wrap 0", rx, 8'h70);
    desel();

    // R8 zero-length burst read
    hwrite(6'h08, 8'h9C);
    sel();
    xfer(8'h21, rx);
    xfer(8'h00, rx);
    xfer(8'hFF, rx); check("R8 N=0 zero", rx, 8'h00);
    desel();
    hcheck("R8 N=0 untouched", 6'h08, 8'h9C);

    // R6 burst write of three bytes
    sel();
    xfer(8'hF7, rx);
    xfer(8'h12, rx); check("R6 miso quiet", rx, 8'h00);
    xfer(8'h34, rx);
    xfer(8'h56, rx); check("R6 miso quiet end", rx, 8'h00);
    desel();
    hcheck("R6 reg 3D", 6'h3D, 8'h12);
    hcheck("R6 reg 3E", 6'h3E, 8'h34);
    hcheck("R6 reg 3F", 6'h3F, 8'h56);

    // R7 burst write across the top address
    sel();
    xfer(8'hFF, rx);
    xfer(8'h11, rx);
    xfer(8'h22, rx);
    desel();
    hcheck("R7 wr 63", 6'd63, 8'h11);
    hcheck("R7 wr wrap 0", 6'd0, 8'h22);

    // R9 single write cut short after four data bits
    hwrite(6'h20, 8'h99);
    sel();
    xfer(8'h82, rx);
    xfer_bits(8'h44, 4, rx);
    desel();
    hcheck("R9 partial single", 6'h20, 8'h99);

    // R9 burst write: one full byte, then a partial one
    hwrite(6'h23, 8'h00); hwrite(6'h24, 8'h77);
    sel();
    xfer(8'h8F, rx);
    xfer(8'hAA, rx);
    xfer_bits(8'hBB, 5, rx);
    desel();
    hcheck("R9 full byte kept", 6'h23, 8'hAA);
    hcheck("R9 partial dropped", 6'h24, 8'h77);

    // R9 partial header, then a clean read frames correctly
    hwrite(6'h16, 8'h5A);
    sel();
    xfer_bits(8'hFF, 5, rx);
    desel();
    sel();
    xfer(8'h58, rx); check("R9 reframed header", rx, 8'h00);
    xfer(8'h00, rx); check("R9 reframed read", rx, 8'h5A);
    desel();

    // R10 host write then read back
    hwrite(6'h2A, 8'hC7);
    hcheck("R10 host rw", 6'h2A, 8'hC7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule